// File: doc/BRIEF.md
# Input Capture Channel with Event Prescaler

This block is a single timer channel running in capture mode. A two-bit routing field either parks the channel as an output, so it never captures, or picks one of three synchronous sources for its capture path: the channel's own conditioned input, the conditioned input of the neighbouring channel, or an internal trigger line. The internal trigger is used only while a separate trigger-enable input is high.

Rising edges on the chosen source are counted by an event prescaler. The prescaler lets through one edge in 1, 2, 4 or 8. Each edge that gets through copies the running timer count into the capture register and raises a capture flag. A capture that lands while the flag is still set also raises an overcapture flag. The routing field can only be rewritten while the channel is disabled. The prescaler counter is held at zero for as long as the channel is disabled.

Top module: `icap_channel`

## Requirements
- R1: After reset the capture register reads 0, both flags read 0, the routing field is 00 (output) and the prescale field is 00.
- R2: With routing 00 the channel performs no capture, whatever its sources do.
- R3: Routing 01 selects the channel's own input, 10 selects the neighbouring input and 11 selects the internal trigger.
- R4: With routing 11, an edge on the trigger causes a capture only while the trigger-enable input is 1 in that cycle.
- R5: A write strobe loads the routing field only while the channel enable is 0. The prescale field is loaded on every write strobe.
- R6: An event is a rising edge: the selected source is 1 in this cycle and was 0 in the previous cycle. A source held high gives exactly one event.
- R7: Prescale 00 captures on every event, 01 on every 2nd event, 10 on every 4th and 11 on every 8th. If the field shrinks mid-count, the next event captures once the count already reaches the new limit.
- R8: While the channel enable is 0 the prescaler count is cleared, events are not counted and no capture occurs.
- R9: On a capture, the timer count present at that clock edge is stored in the capture register, and the capture flag is 1 from the next cycle on.
- R10: The clear strobe resets the capture flag and the overcapture flag. When a capture happens in the same cycle, the capture flag stays set.
- R11: A capture made while the capture flag is already 1 sets the overcapture flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| own_in | input | 1 | Conditioned input of this channel |
| nbr_in | input | 1 | Conditioned input of the neighbouring channel |
| trig_in | input | 1 | Internal trigger line |
| trig_en | input | 1 | Qualifies the trigger source |
| chan_en | input | 1 | Channel enable |
| cfg_wr | input | 1 | Write strobe for the routing and prescale fields |
| cfg_sel | input | 2 | New routing field value |
| cfg_psc | input | PSC_W | New prescale field value |
| cnt_val | input | CNT_W | Running timer count |
| flag_clr | input | 1 | Clear strobe for both flags |
| cap_val | output | CNT_W | Capture register |
| cap_flag | output | 1 | Capture flag |
| ovr_flag | output | 1 | Overcapture flag |

## Verification
The bench builds the block with its defaults, CNT_W of 16 and PSC_W of 2. This makes all four prescale ratios reachable, including the eight-event ratio whose counter runs through its full three-bit range. It also lets random 16-bit timer values show any wrong latch cycle at once. Directed runs cover each routing value, trigger gating, the write lock, a prescale field that shrinks mid-count, and clears that coincide with captures. A long random run then exercises the interactions between these cases.

// File: rtl/icap_pkg.sv
// Shared types for the input capture channel.
package icap_pkg;
    typedef enum logic [1:0] {
        ROUTE_OUTPUT = 2'b00,
        ROUTE_OWN    = 2'b01,
        ROUTE_NEIGH  = 2'b10,
        ROUTE_TRIG   = 2'b11
    } icap_route_e;
endpackage

// File: rtl/icap_source_mux.sv
// Holds the routing field and selects the capture source.
// Assumes all sources are already synchronous to clk.
// The field only updates while the channel is disabled.
module icap_source_mux
    import icap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        own_in,
    input  logic        nbr_in,
    input  logic        trig_in,
    input  logic        trig_en,
    input  logic        chan_en,
    input  logic        cfg_wr,
    input  logic [1:0]  cfg_sel,
    output icap_route_e route_q,
    output logic        src_level
);
    // Routing register: written only while the channel is off.
    always_ff @(posedge clk) begin
        if (!rst_n)
            route_q <= ROUTE_OUTPUT;
        else if (cfg_wr && !chan_en)
            route_q <= icap_route_e'(cfg_sel);
    end

    // Source selection; the trigger is gated by its enable.
    always_comb begin
        unique case (route_q)
            ROUTE_OWN:   src_level = own_in;
            ROUTE_NEIGH: src_level = nbr_in;
            ROUTE_TRIG:  src_level = trig_in & trig_en;
            default:     src_level = 1'b0;
        endcase
    end
endmodule

// File: rtl/icap_edge_prescaler.sv
// Detects rising edges of the selected source and divides them
// by 2**psc. Produces a one-cycle capture event.
// Assumes src_level is registered or glitch-free.
module icap_edge_prescaler #(
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_level,
    input  logic             chan_en,
    input  logic             route_active,
    input  logic             cfg_wr,
    input  logic [PSC_W-1:0] cfg_psc,
    output logic             cap_event
);
    localparam int PCNT_W = (1 << PSC_W) - 1;

    logic              prev_q;
    logic [PSC_W-1:0]  psc_q;
    logic [PCNT_W-1:0] evcnt_q;
    logic [PCNT_W-1:0] limit;
    logic              rise;
    logic              counted;

    // Previous level of the selected source.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src_level;
    end

    // Prescale field, loaded on any write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      psc_q <= '0;
        else if (cfg_wr) psc_q <= cfg_psc;
    end

    // Thermometer limit: 2**psc - 1.
    always_comb begin
        limit = '0;
        for (int i = 0; i < PCNT_W; i++)
            if (i < int'(psc_q)) limit[i] = 1'b1;
    end

    assign rise      = src_level & ~prev_q;
    assign counted   = rise & chan_en & route_active;
    assign cap_event = counted & (evcnt_q >= limit);

    // Event counter: cleared while disabled, wraps on capture.
    always_ff @(posedge clk) begin
        if (!rst_n || !chan_en) evcnt_q <= '0;
        else if (cap_event)     evcnt_q <= '0;
        else if (counted)       evcnt_q <= evcnt_q + 1'b1;
    end
endmodule

// File: rtl/icap_capture_reg.sv
// Capture register and flags. A capture takes priority over a clear.
// Assumes cap_event is a single-cycle pulse per capture.
module icap_capture_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_event,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             ovr_flag
);
    // Latch the timer count on a capture.
    always_ff @(posedge clk) begin
        if (!rst_n)         cap_val <= '0;
        else if (cap_event) cap_val <= cnt_val;
    end

    // Capture flag: set by a capture, otherwise cleared by the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         cap_flag <= 1'b0;
        else if (cap_event) cap_flag <= 1'b1;
        else if (flag_clr)  cap_flag <= 1'b0;
    end

    // Overcapture flag: set by a capture over a pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ovr_flag <= 1'b0;
        else if (cap_event && cap_flag) ovr_flag <= 1'b1;
        else if (flag_clr)             ovr_flag <= 1'b0;
    end
endmodule

// File: rtl/icap_channel.sv
// Top of one input capture channel: source routing, edge prescaler
// and capture register. Assumes synchronous, conditioned inputs.
module icap_channel
    import icap_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             own_in,
    input  logic             nbr_in,
    input  logic             trig_in,
    input  logic             trig_en,
    input  logic             chan_en,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_sel,
    input  logic [PSC_W-1:0] cfg_psc,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             ovr_flag
);
    icap_route_e route_q;
    logic        src_level;
    logic        cap_event;
    logic        route_active;

    assign route_active = (route_q != ROUTE_OUTPUT);

    icap_source_mux u_mux (
        .clk(clk), .rst_n(rst_n), .own_in(own_in), .nbr_in(nbr_in),
        .trig_in(trig_in), .trig_en(trig_en), .chan_en(chan_en),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .route_q(route_q),
        .src_level(src_level)
    );

    icap_edge_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .src_level(src_level), .chan_en(chan_en),
        .route_active(route_active), .cfg_wr(cfg_wr), .cfg_psc(cfg_psc),
        .cap_event(cap_event)
    );

    icap_capture_reg #(.CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap_event(cap_event), .cnt_val(cnt_val),
        .flag_clr(flag_clr), .cap_val(cap_val), .cap_flag(cap_flag),
        .ovr_flag(ovr_flag)
    );
endmodule

// File: rtl/icap_channel_checker.sv
// Temporal properties of the capture channel, bound to the top.
module icap_channel_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_en,
    input logic             chan_en,
    input logic             flag_clr,
    input logic [1:0]       route_q,
    input logic [CNT_W-1:0] cap_val,
    input logic             cap_flag,
    input logic             ovr_flag
);
    p_output_no_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (route_q == 2'b00 && !cap_flag) |=> !cap_flag);

    p_trigger_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (route_q == 2'b11 && !trig_en && !cap_flag) |=> !cap_flag);

    p_route_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en |=> $stable(route_q));

    p_disabled_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> ($stable(cap_val) && ($stable(cap_flag) || $fell(cap_flag))));

    p_value_with_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_val) |-> cap_flag);

    p_fall_needs_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cap_flag) |-> $past(flag_clr));

    p_overcapture_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $past(cap_flag));
endmodule

bind icap_channel icap_channel_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .trig_en(trig_en), .chan_en(chan_en),
    .flag_clr(flag_clr), .route_q(route_q), .cap_val(cap_val),
    .cap_flag(cap_flag), .ovr_flag(ovr_flag)
);

// File: tb/icap_channel_test.sv
module icap_channel_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16;
    localparam int PSC_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic own_in = 0, nbr_in = 0, trig_in = 0, trig_en = 0, chan_en = 0;
    logic cfg_wr = 0, flag_clr = 0;
    logic [1:0] cfg_sel = 0;
    logic [PSC_W-1:0] cfg_psc = 0;
    logic [CNT_W-1:0] cnt_val = 0;
    logic [CNT_W-1:0] cap_val;
    logic cap_flag, ovr_flag;

    int checks = 0, failures = 0;
    bit done = 0;

    // Reference model state
    int m_sel, m_psc, m_cnt;
    bit m_prev, m_flag, m_ovr;
    logic [CNT_W-1:0] m_cap;

    always #(CLK_PERIOD/2) clk = ~clk;

    icap_channel #(.CNT_W(CNT_W), .PSC_W(PSC_W)) uut (
        .clk(clk), .rst_n(rst_n), .own_in(own_in), .nbr_in(nbr_in),
        .trig_in(trig_in), .trig_en(trig_en), .chan_en(chan_en),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_psc(cfg_psc),
        .cnt_val(cnt_val), .flag_clr(flag_clr), .cap_val(cap_val),
        .cap_flag(cap_flag), .ovr_flag(ovr_flag)
    );

    function automatic bit route_src(int sel);
        case (sel)
            1: return own_in;
            2: return nbr_in;
            3: return trig_in & trig_en;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sel = 0; m_psc = 0; m_cnt = 0; m_prev = 0;
        m_flag = 0; m_ovr = 0; m_cap = '0;
    endtask

    // Apply current inputs for one clock and compare with the model.
    task automatic step(string tag);
        bit src, rise, ev;
        src  = route_src(m_sel);
        rise = src && !m_prev;
        ev   = rise && chan_en && (m_sel != 0) && (m_cnt >= (1 << m_psc) - 1);
        m_prev = src;
        if (!chan_en) m_cnt = 0;
        else if (ev) m_cnt = 0;
        else if (rise && m_sel != 0) m_cnt++;
        if (ev) m_cap = cnt_val;
        if (ev && m_flag) m_ovr = 1; else if (!ev && flag_clr) m_ovr = 0;
        if (ev) m_flag = 1; else if (flag_clr) m_flag = 0;
        if (cfg_wr) m_psc = int'(cfg_psc);
        if (cfg_wr && !chan_en) m_sel = int'(cfg_sel);
        @(posedge clk);
        @(negedge clk);
        check({tag, " cap_val"}, cap_val, m_cap);
        check({tag, " cap_flag"}, cap_flag, m_flag);
        check({tag, " ovr_flag"}, ovr_flag, m_ovr);
        cfg_wr = 0; flag_clr = 0;
    endtask

    task automatic configure(int sel, int psc, string tag);
        chan_en = 0; cfg_wr = 1; cfg_sel = 2'(sel); cfg_psc = PSC_W'(psc);
        step(tag);
        chan_en = 1;
    endtask

    task automatic pulse_own(int n, string tag);
        for (int i = 0; i < n; i++) begin
            own_in = 1; cnt_val = CNT_W'($urandom); step(tag);
            own_in = 0; step(tag);
        end
    endtask

    initial begin
        repeat (1000 * 200) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1C4A7));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 cap_val", cap_val, 0);
        check("R1 cap_flag", cap_flag, 0);
        check("R1 ovr_flag", ovr_flag, 0);

        // R2: routing 00 never captures
        chan_en = 1;
        pulse_own(3, "R2");
        check("R2 no capture", cap_flag, 0);

        // R3/R9: own input, every edge, exact value latched
        configure(1, 0, "R3");
        own_in = 1; cnt_val = 16'hBEEF; step("R9");
        check("R9 value", cap_val, 16'hBEEF);
        // R6: held high gives no second event
        cnt_val = 16'h1234; step("R6"); step("R6");
        check("R6 held level", cap_val, 16'hBEEF);
        own_in = 0; flag_clr = 1; step("R10");
        check("R10 cleared", cap_flag, 0);

        // R3: neighbour routing ignores own input
        configure(2, 0, "R3");
        pulse_own(2, "R3");
        check("R3 own ignored", cap_flag, 0);
        nbr_in = 1; cnt_val = 16'h00A5; step("R3"); nbr_in = 0; step("R3");
        check("R3 neighbour", cap_val, 16'h00A5);

        // R4: trigger gated by its enable
        flag_clr = 1; step("R10");
        configure(3, 0, "R4");
        trig_in = 1; trig_en = 0; step("R4"); trig_in = 0; step("R4");
        check("R4 gated", cap_flag, 0);
        trig_in = 1; trig_en = 1; cnt_val = 16'h7777; step("R4");
        trig_in = 0; step("R4");
        check("R4 enabled", cap_val, 16'h7777);

        // R5: routing locked while enabled
        cfg_wr = 1; cfg_sel = 2'b01; cfg_psc = 0; step("R5");
        pulse_own(2, "R5");
        check("R5 lock", cap_val, 16'h7777);

        // R7: every 8th event, R11 overcapture
        configure(1, 3, "R7");
        pulse_own(7, "R7");
        check("R7 before 8th", cap_val, 16'h7777);
        pulse_own(1, "R7");
        check("R11 overcapture", ovr_flag, 1);

        // R7: shrink mid-count, R8 clear on disable
        configure(1, 2, "R7");
        pulse_own(3, "R7");
        cfg_wr = 1; cfg_psc = 1; step("R7");
        pulse_own(1, "R7");
        pulse_own(2, "R8");
        chan_en = 0; step("R8"); pulse_own(2, "R8"); chan_en = 1;
        pulse_own(3, "R8");

        // R10: clear coinciding with capture keeps the flag
        configure(1, 0, "R10");
        own_in = 1; flag_clr = 1; step("R10"); own_in = 0; step("R10");
        check("R10 capture wins", cap_flag, 1);

        // Random mix over R2..R11
        for (int i = 0; i < 4000; i++) begin
            own_in   = ($urandom % 3) == 0;
            nbr_in   = ($urandom % 3) == 0;
            trig_in  = ($urandom % 3) == 0;
            trig_en  = ($urandom % 2) == 0;
            chan_en  = ($urandom % 8) != 0;
            cfg_wr   = ($urandom % 16) == 0;
            cfg_sel  = 2'($urandom);
            cfg_psc  = PSC_W'($urandom);
            flag_clr = ($urandom % 6) == 0;
            cnt_val  = CNT_W'($urandom);
            step("R7/R9/R10/R11 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule